// File: doc/BRIEF.md
# Vertical Column Defect Corrector

This block is a streaming stage for raw sensor pixels that repairs image columns damaged by a faulty sensor. It keeps a small table of defective columns. Each entry gives the column's horizontal position, a reference row, and three subtraction levels: one for rows above the reference row, one for the reference row itself, and one for rows below it. The block counts rows and columns from the stream's start-of-frame and start-of-line markers. When a pixel lands on a listed column, the level picked by the pixel's row is subtracted from the pixel value, and the result is clamped at zero.

Software fills the table through a plain write port and sets an enable bit, a 2-bit method field and an entry count. Only the subtraction method changes data; every other method code lets pixels through unchanged. Table entries must be stored in ascending column order. This lets a single pointer walk along each line and replaces a bank of parallel comparators. Table writes are blocked while correction is enabled, so the table cannot change under a line that is being corrected.

Top module: `vcol_defect_fix`

## Requirements
- R1: After reset, out_valid, out_sof, out_sol and out_pix are 0, correction is disabled, the entry count is 0 and every table entry is zero.
- R2: out_valid equals in_valid of the previous cycle. out_sof and out_sol equal in_sof and in_sol of the previous cycle, each ANDed with that cycle's in_valid. When out_valid is 1, out_pix is the result for the previous cycle's in_pix.
- R3: The control word sits at address 8: bit 0 is enable, bits 2:1 are the method, bits 6:3 are the count. Pixels pass through unchanged when enable is 0 or when the method is anything other than 2'b01.
- R4: Entries sit at addresses 0 to 7, with the reference row in bits 12:0, the column in bits 25:13, the level for the reference row in bits 33:26, the level for rows above it in bits 41:34 and the level for rows below it in bits 49:42. On a listed column, a row number lower than the reference row subtracts the level in bits 41:34.
- R5: On a listed column, a row number equal to the reference row subtracts the level in bits 33:26.
- R6: On a listed column, a row number greater than the reference row subtracts the level in bits 49:42.
- R7: When the selected level exceeds the pixel value, the output is 0. An output is never greater than its input pixel.
- R8: A valid pixel with in_sof is row 0, column 0. A valid pixel with in_sol (and no in_sof) starts the next row at column 0. Every other valid pixel is one column to the right of the previous valid pixel. Invalid cycles advance neither counter.
- R9: Only entries at addresses below the programmed count can correct pixels. A count written above 8 is clamped to 8. Entries below the count are matched in ascending address order along each line.
- R10: Writes to table entries are ignored while enable is 1 and are applied while enable is 0. Writes to the control word are always applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: 0 to 7 select a table entry, 8 selects the control word |
| wr_data | input | 50 | Write data (a full entry, or the control fields in the low bits) |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | Input pixel is the first pixel of a frame |
| in_sol | input | 1 | Input pixel is the first pixel of a line |
| in_pix | input | 14 | Input pixel value |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Output start-of-frame marker |
| out_sol | output | 1 | Output start-of-line marker |
| out_pix | output | 14 | Corrected pixel value |

## Verification
The assertions assume that in_sof and in_sol are set only on valid cycles. They also assume the pixel stream opens each frame with in_sof before any other line starts. The pointer checks further assume that the entries below the count hold distinct columns in ascending order. The stimulus keeps within these limits: every line starts with a marked valid pixel, and the table holds strictly increasing columns. The entries past the count are the only ones left out of order, and the count is never raised to reach them. Idle gaps appear only inside lines, and table writes happen only between lines. The bench is therefore free to model matching as a simple scan over the table.

// File: rtl/vcd_pkg.sv
`timescale 1ns/1ps
// Package: shared layout and types for the vertical column defect corrector.
// Assumes a fixed 50-bit table entry and fixed positions for the control fields.
package vcd_pkg;
    localparam int ENT_W        = 50;
    localparam int POS_W        = 13;
    localparam int LVL_W        = 8;
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_METH_LSB = 1;
    localparam int CTL_CNT_LSB  = 3;

    typedef enum logic [1:0] {
        METH_NONE = 2'd0,
        METH_SUB  = 2'd1,
        METH_ALT2 = 2'd2,
        METH_ALT3 = 2'd3
    } meth_e;

    // Packed entry, MSB first: below, above, at levels, column, reference row
    typedef struct packed {
        logic [LVL_W-1:0] lvl_dn;
        logic [LVL_W-1:0] lvl_up;
        logic [LVL_W-1:0] lvl_at;
        logic [POS_W-1:0] hpos;
        logic [POS_W-1:0] vpos;
    } entry_t;
endpackage

// File: rtl/vcd_regs.sv
`timescale 1ns/1ps
// Module: vcd_regs
// Holds the control word (enable, method, count) and the defect table.
// Assumes address MAX_ENT is the control word and lower addresses are entries.
// Table writes are dropped while enable is set; control writes always land.
module vcd_regs
    import vcd_pkg::*;
#(
    parameter int MAX_ENT = 8,
    parameter int ADDR_W  = 4,
    parameter int CNT_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [ENT_W-1:0]         wr_data,
    output logic                     ctl_en,
    output meth_e                    ctl_meth,
    output logic [CNT_W-1:0]         ctl_cnt,
    output entry_t [MAX_ENT-1:0]     tbl
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(MAX_ENT);
    localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(MAX_ENT);

    logic [CNT_W-1:0] cnt_req;
    logic             ctl_hit;
    entry_t           ent_q [MAX_ENT];

    // Decode the control write and extract the requested count
    always_comb begin
        ctl_hit = wr_en && (wr_addr == CTL_ADDR);
        cnt_req = wr_data[CTL_CNT_LSB +: CNT_W];
    end

    // Control word register with the count clamped to the table depth
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en   <= 1'b0;
            ctl_meth <= METH_NONE;
            ctl_cnt  <= '0;
        end else if (ctl_hit) begin
            ctl_en   <= wr_data[CTL_EN_BIT];
            ctl_meth <= meth_e'(wr_data[CTL_METH_LSB +: 2]);
            ctl_cnt  <= (cnt_req > CNT_MAX) ? CNT_MAX : cnt_req;
        end
    end

    for (genvar gi = 0; gi < MAX_ENT; gi++) begin : g_ent
        // One table entry, writable only while correction is disabled
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[gi] <= '0;
            end else if (wr_en && !ctl_en && (wr_addr == ADDR_W'(gi))) begin
                ent_q[gi] <= entry_t'(wr_data);
            end
        end
        assign tbl[gi] = ent_q[gi];
    end
endmodule

// File: rtl/vcd_locate.sv
`timescale 1ns/1ps
// Module: vcd_locate
// Tracks row and column of each valid pixel and walks the sorted table with a
// single pointer. Flags a hit on a listed column and picks the level by row.
// Assumes in_sof/in_sol arrive only with in_valid, and entries below the count
// are in ascending column order.
module vcd_locate
    import vcd_pkg::*;
#(
    parameter int MAX_ENT = 8,
    parameter int CNT_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_sof,
    input  logic                     in_sol,
    input  logic [CNT_W-1:0]         ctl_cnt,
    input  entry_t [MAX_ENT-1:0]     tbl,
    output logic                     hit,
    output logic [LVL_W-1:0]         level,
    output logic [POS_W-1:0]         row_q,
    output logic [POS_W-1:0]         col_q,
    output logic [CNT_W-1:0]         ptr_q
);
    logic [POS_W-1:0] row_cur;
    logic [POS_W-1:0] col_cur;
    logic [CNT_W-1:0] ptr_cur;
    entry_t           ent_sel;

    // Position of the current pixel, with the markers restarting the counts
    always_comb begin
        if (in_sof) begin
            row_cur = '0;
            col_cur = '0;
            ptr_cur = '0;
        end else if (in_sol) begin
            row_cur = row_q + 1'b1;
            col_cur = '0;
            ptr_cur = '0;
        end else begin
            row_cur = row_q;
            col_cur = col_q;
            ptr_cur = ptr_q;
        end
    end

    // Fetch the entry under the pointer
    always_comb begin
        ent_sel = '0;
        for (int i = 0; i < MAX_ENT; i++) begin
            if (ptr_cur == CNT_W'(i)) ent_sel = tbl[i];
        end
    end

    // Column match against the pointed entry and row-based level choice
    always_comb begin
        hit = in_valid && (ptr_cur < ctl_cnt) && (ent_sel.hpos == col_cur);
        if (row_cur < ent_sel.vpos)       level = ent_sel.lvl_up;
        else if (row_cur == ent_sel.vpos) level = ent_sel.lvl_at;
        else                              level = ent_sel.lvl_dn;
    end

    // Advance counters and pointer on each valid pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
            ptr_q <= '0;
        end else if (in_valid) begin
            row_q <= row_cur;
            col_q <= col_cur + 1'b1;
            ptr_q <= ptr_cur + CNT_W'(hit);
        end
    end
endmodule

// File: rtl/vcd_apply.sv
`timescale 1ns/1ps
// Module: vcd_apply
// Subtracts the chosen level with a floor at zero and registers the pixel,
// valid and markers so the stage has exactly one cycle of latency.
// Assumes level is already selected for the current pixel.
module vcd_apply
    import vcd_pkg::*;
#(
    parameter int PIX_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic               in_sol,
    input  logic [PIX_W-1:0]   in_pix,
    input  logic               do_fix,
    input  logic [LVL_W-1:0]   level,
    output logic               out_valid,
    output logic               out_sof,
    output logic               out_sol,
    output logic [PIX_W-1:0]   out_pix
);
    logic [PIX_W:0]   diff;
    logic [PIX_W-1:0] fixed;

    // Subtraction with borrow detection for the zero clamp
    always_comb begin
        diff  = {1'b0, in_pix} - {{(PIX_W+1-LVL_W){1'b0}}, level};
        fixed = diff[PIX_W] ? '0 : diff[PIX_W-1:0];
    end

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_sol   <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= in_valid;
            out_sof   <= in_valid && in_sof;
            out_sol   <= in_valid && in_sol;
            out_pix   <= do_fix ? fixed : in_pix;
        end
    end
endmodule

// File: rtl/vcol_defect_fix.sv
`timescale 1ns/1ps
// Module: vcol_defect_fix
// Top of the vertical column defect corrector: register file, position and
// pointer tracker, and subtract/output stage.
// Assumes markers only with valid and a table sorted by column.
module vcol_defect_fix
    import vcd_pkg::*;
#(
    parameter  int MAX_ENT = 8,
    parameter  int PIX_W   = 14,
    localparam int ADDR_W  = $clog2(MAX_ENT + 1),
    localparam int CNT_W   = $clog2(MAX_ENT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [ENT_W-1:0]   wr_data,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic               in_sol,
    input  logic [PIX_W-1:0]   in_pix,
    output logic               out_valid,
    output logic               out_sof,
    output logic               out_sol,
    output logic [PIX_W-1:0]   out_pix
);
    logic                 ctl_en;
    meth_e                ctl_meth;
    logic [CNT_W-1:0]     ctl_cnt;
    entry_t [MAX_ENT-1:0] tbl;
    logic                 hit;
    logic [LVL_W-1:0]     level;
    logic [POS_W-1:0]     row_q;
    logic [POS_W-1:0]     col_q;
    logic [CNT_W-1:0]     ptr_q;
    logic                 do_fix;

    vcd_regs #(.MAX_ENT(MAX_ENT), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctl_en   (ctl_en),
        .ctl_meth (ctl_meth),
        .ctl_cnt  (ctl_cnt),
        .tbl      (tbl)
    );

    vcd_locate #(.MAX_ENT(MAX_ENT), .CNT_W(CNT_W)) u_locate (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_sol   (in_sol),
        .ctl_cnt  (ctl_cnt),
        .tbl      (tbl),
        .hit      (hit),
        .level    (level),
        .row_q    (row_q),
        .col_q    (col_q),
        .ptr_q    (ptr_q)
    );

    // Correction applies only when enabled, in subtraction mode, on a hit
    always_comb do_fix = hit && ctl_en && (ctl_meth == METH_SUB);

    vcd_apply #(.PIX_W(PIX_W)) u_apply (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_sol    (in_sol),
        .in_pix    (in_pix),
        .do_fix    (do_fix),
        .level     (level),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_sol   (out_sol),
        .out_pix   (out_pix)
    );
endmodule

// File: rtl/vcd_checker.sv
`timescale 1ns/1ps
// Module: vcd_checker
// Concurrent properties for vcol_defect_fix, attached by bind below.
// Assumes markers only with valid.
module vcd_checker #(
    parameter int PIX_W  = 14,
    parameter int POS_W  = 13,
    parameter int TBL_W  = 400
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sof,
    input logic              in_sol,
    input logic [PIX_W-1:0]  in_pix,
    input logic              out_valid,
    input logic              out_sof,
    input logic [PIX_W-1:0]  out_pix,
    input logic              ctl_en,
    input logic [1:0]        ctl_meth,
    input logic [TBL_W-1:0]  tbl,
    input logic [POS_W-1:0]  row_q,
    input logic [POS_W-1:0]  col_q
);
    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
    AST_IDLE_DELAY: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
    AST_SOF_DELAY: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_sof) |=> out_sof); // R2
    AST_NEVER_GROWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> (out_pix <= $past(in_pix))); // R7
    AST_BYPASS_OFF: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && (!ctl_en || ctl_meth != 2'b01)) |=> (out_pix == $past(in_pix))); // R3
    AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) ctl_en |=> $stable(tbl)); // R10
    AST_ROW_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_sof) |=> (row_q == '0)); // R8
    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !in_sof && !in_sol) |=> (col_q == $past(col_q) + 1'b1)); // R8
endmodule

bind vcol_defect_fix vcd_checker #(
    .PIX_W (PIX_W),
    .POS_W (vcd_pkg::POS_W),
    .TBL_W (MAX_ENT * vcd_pkg::ENT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_sol    (in_sol),
    .in_pix    (in_pix),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_pix   (out_pix),
    .ctl_en    (ctl_en),
    .ctl_meth  (ctl_meth),
    .tbl       (tbl),
    .row_q     (row_q),
    .col_q     (col_q)
);

// File: tb/tb_vcol_defect_fix.sv
`timescale 1ns/1ps
// Bench: behavioural model (integer row/column counters, table scan) compared
// with the design on every clock.
module tb_vcol_defect_fix;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [49:0] wr_data = '0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic        in_sol = 1'b0;
    logic [13:0] in_pix = '0;
    logic        out_valid;
    logic        out_sof;
    logic        out_sol;
    logic [13:0] out_pix;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // model state
    int m_v [8], m_h [8], m_at [8], m_up [8], m_dn [8];
    int m_cnt = 0, m_meth = 0;
    bit m_en = 1'b0;
    int m_row = 0, m_col = 0;
    bit exp_valid = 1'b0, exp_sof = 1'b0, exp_sol = 1'b0;
    int exp_pix = 0;
    string exp_tag = "R1";
    string phase = "R1";

    vcol_defect_fix dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol), .in_pix(in_pix),
        .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol), .out_pix(out_pix)
    );

    always #4 clk = ~clk;

    function automatic logic [49:0] mk(int v, int h, int at, int up, int dn);
        return {dn[7:0], up[7:0], at[7:0], h[12:0], v[12:0]};
    endfunction

    task automatic check_out();
        checks++;
        if (out_valid !== exp_valid || out_sof !== exp_sof || out_sol !== exp_sol) begin
            errors++;
            $display("FAIL R2: valid/sof/sol actual=%b%b%b expected=%b%b%b",
                     out_valid, out_sof, out_sol, exp_valid, exp_sof, exp_sol);
        end
        if (exp_valid) begin
            checks++;
            if (int'(out_pix) != exp_pix) begin
                errors++;
                $display("FAIL %s: out_pix actual=%0d expected=%0d (row %0d)",
                         exp_tag, out_pix, exp_pix, m_row);
            end
        end
    endtask

    // One clock: check previous result, model this cycle, drive inputs
    task automatic step(input bit v, input bit sof, input bit sol, input int pix,
                        input bit we, input int wa, input logic [49:0] wd);
        int lvl, res, idx;
        check_out();
        exp_valid = v;
        exp_sof   = v && sof;
        exp_sol   = v && sol;
        if (v) begin
            if (sof) begin m_row = 0; m_col = 0; end
            else if (sol) begin m_row++; m_col = 0; end
            idx = -1;
            for (int i = 0; i < m_cnt; i++) if (idx < 0 && m_h[i] == m_col) idx = i;
            exp_pix = pix;
            exp_tag = phase;
            if (idx >= 0 && m_en && m_meth == 1) begin
                if (m_row < m_v[idx]) begin lvl = m_up[idx]; exp_tag = "R4"; end
                else if (m_row == m_v[idx]) begin lvl = m_at[idx]; exp_tag = "R5"; end
                else begin lvl = m_dn[idx]; exp_tag = "R6"; end
                res = pix - lvl;
                if (res < 0) begin res = 0; exp_tag = "R7"; end
                exp_pix = res;
            end
            m_col++;
        end
        if (we) begin
            if (wa == 8) begin
                m_en   = wd[0];
                m_meth = int'(wd[2:1]);
                m_cnt  = int'(wd[6:3]);
                if (m_cnt > 8) m_cnt = 8;
            end else if (wa < 8 && !m_en) begin
                m_v[wa] = int'(wd[12:0]);  m_h[wa] = int'(wd[25:13]);
                m_at[wa] = int'(wd[33:26]); m_up[wa] = int'(wd[41:34]);
                m_dn[wa] = int'(wd[49:42]);
            end
        end
        in_valid = v; in_sof = sof; in_sol = sol; in_pix = 14'(pix);
        wr_en = we; wr_addr = 4'(wa); wr_data = wd;
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [49:0] d);
        step(1'b0, 1'b0, 1'b0, 0, 1'b1, a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 0, 1'b0, 0, '0);
    endtask

    // One line of n pixels, pix = base + col*mult (mod 2^14), gap every 5th
    task automatic line(input bit first_sof, input int n, input int base, input int mult);
        for (int c = 0; c < n; c++) begin
            if (c > 0 && c % 5 == 0) idle(1);
            step(1'b1, first_sof && c == 0, !first_sof && c == 0,
                 (base + c * mult) % 16384, 1'b0, 0, '0);
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m_v[i]=0; m_h[i]=0; m_at[i]=0; m_up[i]=0; m_dn[i]=0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        checks++;
        if (out_valid !== 1'b0 || out_pix !== 14'd0) begin
            errors++;
            $display("FAIL R1: valid/pix actual=%b/%0d expected=0/0", out_valid, out_pix);
        end
        // R1: table and count are zero, so a line at column 0 passes through
        phase = "R1";
        line(1'b1, 3, 77, 5);
        idle(2);

        phase = "R9";
        wr(0, mk(1, 2, 10, 20, 30));
        wr(1, mk(2, 5, 100, 3, 200));
        wr(2, mk(0, 9, 7, 7, 7));
        wr(3, mk(1, 12, 40, 40, 40));
        wr(8, 50'd27);                 // en=1, method=01, count=3
        idle(1);
        phase = "R8";
        line(1'b1, 14, 500, 3);
        for (int r = 1; r < 4; r++) line(1'b0, 14, 600 + r * 50, 7);
        // R7: small pixel values on defect columns force the clamp
        line(1'b0, 14, 0, 2);
        line(1'b0, 14, 16300, 5);
        idle(2);

        // R10: entry write while enabled must be ignored
        phase = "R10";
        wr(0, mk(0, 2, 1, 1, 1));
        line(1'b0, 14, 900, 4);
        idle(1);

        // R3: alternative method and disabled both pass through
        phase = "R3";
        wr(8, 50'd29);                 // en=1, method=10, count=3
        line(1'b0, 14, 800, 9);
        wr(8, 50'd26);                 // en=0, method=01, count=3
        line(1'b0, 14, 800, 9);

        // R10: write while disabled is applied
        phase = "R10";
        wr(0, mk(0, 2, 60, 61, 62));
        wr(8, 50'd35);                 // en=1, method=01, count=4
        idle(1);
        phase = "R9";
        line(1'b1, 14, 1000, 11);      // R8: new frame restarts rows
        line(1'b0, 14, 1000, 11);
        line(1'b0, 14, 30, 1);
        // R9: count written above 8 clamps to 8, entries 4..7 set sorted
        wr(8, 50'd26);
        wr(4, mk(3, 13, 9, 8, 7));
        wr(5, mk(3, 15, 19, 18, 17));
        wr(6, mk(3, 17, 29, 28, 27));
        wr(7, mk(3, 19, 39, 38, 37));
        wr(8, 50'd123);                // en=1, method=01, count=15 -> 8
        idle(1);
        for (int r = 0; r < 5; r++) line(r == 0, 22, 2000 + r, 13);
        idle(3);
        check_out();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R2: actual=hung expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule